// File: doc/BRIEF.md
# Element Byte-Lane Write Generator

This block converts a single vector element write into a byte-masked register-file write. A vector of elements is laid out back to back, from bit 0 upward, across consecutive 64-bit registers starting at a base register. For each element the block works out which register holds it, which byte lanes it occupies, and where its bits sit on the 64-bit write bus. The element's predicate bit is spread across exactly those lanes. A narrow element can therefore be written without reading the register first.

The element width can be set to 8, 16, 32 or 64 bits. At 64 bits the write is identical to an ordinary scalar register write. A behavioural register file with byte write enables is included, with one write port and one combinational read port, so that the packing can be observed.

Top module: `elem_byte_wr`

## Requirements
- R1: With `width_sel_i` = 2'b00 (64-bit), an active write targets register `base + idx` (mod 128) and drives `rf_be_o` = 8'hFF. The whole element value is written unchanged.
- R2: With `width_sel_i` = 2'b01 (32-bit), an active write targets register `base + idx/2`. It drives `rf_be_o` = 8'h0F for an even index and 8'hF0 for an odd index.
- R3: With `width_sel_i` = 2'b10 (16-bit), an active write targets register `base + idx/4` with two enables at byte offset `2*(idx mod 4)`. For example, index 4 from base r1 writes only bits 15:0 of r2.
- R4: With `width_sel_i` = 2'b11 (8-bit), an active write targets register `base + idx/8` with exactly one enable, at bit `idx mod 8` of `rf_be_o`.
- R5: When `pred_i` is 0, `rf_be_o` is 8'h00 and no register changes.
- R6: When `wr_valid_i` is 0, `rf_be_o` is 8'h00 and no register changes.
- R7: At the clock edge of an active write, only the enabled bytes of the target register take new values; every other byte of every register keeps its value.
- R8: The target register number wraps modulo 128.
- R9: On every enabled lane, `rf_wdata_o` carries the element's low bytes shifted left by eight times the byte offset.
- R10: After reset every register reads zero.
- R11: `rd_data_o` shows the contents of register `rd_addr_i` combinationally, including a write made at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Element write request |
| width_sel_i | input | 2 | Element width: 00=64, 01=32, 10=16, 11=8 bits |
| elem_idx_i | input | 7 | Element index within the vector |
| base_reg_i | input | 7 | First register of the vector |
| elem_data_i | input | 64 | Element result, right-aligned |
| pred_i | input | 1 | Predicate bit of the element |
| rf_reg_o | output | 7 | Target register number |
| rf_wdata_o | output | 64 | Write data placed in byte lanes |
| rf_be_o | output | 8 | Byte write enables |
| rd_addr_i | input | 7 | Read port register number |
| rd_data_o | output | 64 | Read port data |

## Verification
Register number, enables and lane data are combinational in the request. They are due in the same cycle, so the bench samples them one time unit after it drives inputs at the falling edge. The register-file update happens at the next rising edge. The bench checks it through the read port one time unit after that edge, comparing it with a byte-masked reference model. The random stimulus uses a fixed seed and is mixed with directed cases: the fifth 16-bit element, register wrap, and cleared predicate or valid.

// File: rtl/ewbe_pkg.sv
package ewbe_pkg;
  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } ew_e;

  localparam int unsigned DATA_W  = 64;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);

  // log2 of element size in bytes; 64-bit -> 3 ... 8-bit -> 0
  function automatic logic [1:0] size_log2(input ew_e w);
    return ~w;
  endfunction
endpackage

// File: rtl/ewbe_lane_map.sv
module ewbe_lane_map
  import ewbe_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned REG_W = 7
) (
  input  logic [IDX_W-1:0] elem_idx_i,
  input  ew_e              width_i,
  input  logic [REG_W-1:0] base_reg_i,
  output logic [REG_W-1:0] reg_o,
  output logic [OFF_W-1:0] off_o,
  output logic [1:0]       lg_o
);
  localparam int unsigned POS_W = IDX_W + 3;

  logic [POS_W-1:0] byte_pos;
  logic [POS_W-1:0] reg_step;

  always_comb begin
    lg_o     = size_log2(width_i);
    byte_pos = POS_W'(elem_idx_i) << lg_o;
    reg_step = byte_pos >> OFF_W;
    off_o    = byte_pos[OFF_W-1:0];
    reg_o    = base_reg_i + REG_W'(reg_step);
  end
endmodule

// File: rtl/ewbe_strobe.sv
module ewbe_strobe
  import ewbe_pkg::*;
(
  input  logic             active_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       lg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LANES-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [OFF_W:0] span_end;

  always_comb begin
    span_end = {1'b0, off_i} + ((OFF_W+1)'(1) << lg_i);
    wdata_o  = data_i << {off_i, 3'b000};
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_comb begin
      be_o[b] = active_i && ((OFF_W+1)'(b) >= {1'b0, off_i})
                         && ((OFF_W+1)'(b) <  span_end);
    end
  end
endmodule

// File: rtl/ewbe_rf.sv
module ewbe_rf
  import ewbe_pkg::*;
#(
  parameter int unsigned NUM_REGS = 128,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  wr_addr_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < LANES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mem_q[r][b*8 +: 8] <= '0;
        end else if (wr_be_i[b] && wr_addr_i == REG_W'(r)) begin
          mem_q[r][b*8 +: 8] <= wr_data_i[b*8 +: 8];
        end
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/elem_byte_wr.sv
module elem_byte_wr
  import ewbe_pkg::*;
#(
  parameter int unsigned IDX_W    = 7,
  parameter int unsigned NUM_REGS = 128,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [1:0]        width_sel_i,
  input  logic [IDX_W-1:0]  elem_idx_i,
  input  logic [REG_W-1:0]  base_reg_i,
  input  logic [63:0]       elem_data_i,
  input  logic              pred_i,
  output logic [REG_W-1:0]  rf_reg_o,
  output logic [63:0]       rf_wdata_o,
  output logic [7:0]        rf_be_o,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [63:0]       rd_data_o
);
  logic [OFF_W-1:0] off;
  logic [1:0]       lg;

  ewbe_lane_map #(.IDX_W(IDX_W), .REG_W(REG_W)) u_map (
    .elem_idx_i (elem_idx_i),
    .width_i    (ew_e'(width_sel_i)),
    .base_reg_i (base_reg_i),
    .reg_o      (rf_reg_o),
    .off_o      (off),
    .lg_o       (lg)
  );

  ewbe_strobe u_strobe (
    .active_i (wr_valid_i & pred_i),
    .off_i    (off),
    .lg_i     (lg),
    .data_i   (elem_data_i),
    .be_o     (rf_be_o),
    .wdata_o  (rf_wdata_o)
  );

  ewbe_rf #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_addr_i (rf_reg_o),
    .wr_be_i   (rf_be_o),
    .wr_data_i (rf_wdata_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/ewbe_checker.sv
module ewbe_checker #(
  parameter int unsigned REG_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic [1:0]       width_sel_i,
  input logic             pred_i,
  input logic [7:0]       rf_be_o,
  input logic [REG_W-1:0] rd_addr_i,
  input logic [63:0]      rd_data_o
);
  a_r1_full_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && pred_i && width_sel_i == 2'b00) |-> rf_be_o == 8'hFF);

  a_r2_word_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && pred_i && width_sel_i == 2'b01) |->
      (rf_be_o == 8'h0F || rf_be_o == 8'hF0));

  a_r3_half_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && pred_i && width_sel_i == 2'b10) |-> $countones(rf_be_o) == 2);

  a_r4_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && pred_i && width_sel_i == 2'b11) |-> $countones(rf_be_o) == 1);

  a_r5_pred_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_i |-> rf_be_o == 8'h00);

  a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |-> rf_be_o == 8'h00);

  // R7: with no lane enabled, a held read address sees held data
  a_r7_no_write_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_be_o == 8'h00) |=> ($stable(rd_addr_i) |-> $stable(rd_data_o)));
endmodule

bind elem_byte_wr ewbe_checker #(.REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .width_sel_i (width_sel_i),
  .pred_i      (pred_i),
  .rf_be_o     (rf_be_o),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o)
);

// File: tb/elem_byte_wr_tb.sv
module elem_byte_wr_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [1:0]  width_sel_i = 2'b00;
  logic [6:0]  elem_idx_i = '0;
  logic [6:0]  base_reg_i = '0;
  logic [63:0] elem_data_i = '0;
  logic        pred_i = 1'b0;
  logic [6:0]  rf_reg_o;
  logic [63:0] rf_wdata_o;
  logic [7:0]  rf_be_o;
  logic [6:0]  rd_addr_i = '0;
  logic [63:0] rd_data_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] model [128];

  elem_byte_wr u_dut (
    .clk_i, .rst_ni, .wr_valid_i, .width_sel_i, .elem_idx_i, .base_reg_i,
    .elem_data_i, .pred_i, .rf_reg_o, .rf_wdata_o, .rf_be_o, .rd_addr_i,
    .rd_data_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] w);
    case (w)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic v, input logic [1:0] w, input logic [6:0] idx,
                       input logic [6:0] base, input logic [63:0] d, input logic p);
    int nb, bp, off;
    logic [6:0] ereg;
    logic [7:0] ebe;
    logic [63:0] mask, edata;
    @(negedge clk_i);
    wr_valid_i = v; width_sel_i = w; elem_idx_i = idx;
    base_reg_i = base; elem_data_i = d; pred_i = p;
    nb = 1 << (3 - int'(w));
    bp = int'(idx) * nb;
    off = bp % 8;
    ereg = 7'((int'(base) + bp / 8) % 128);
    ebe = (v && p) ? 8'(((1 << nb) - 1) << off) : 8'h00;
    mask = '0;
    for (int b = 0; b < 8; b++) if (ebe[b]) mask[b*8 +: 8] = 8'hFF;
    edata = (d << (off * 8)) & mask;
    rd_addr_i = ereg;
    #1;
    if (!p) chk("R5", {56'h0, rf_be_o}, 64'h0);
    else if (!v) chk("R6", {56'h0, rf_be_o}, 64'h0);
    else chk(req_of(w), {56'h0, rf_be_o}, {56'h0, ebe});
    if (v && p) begin
      chk("R8", {57'h0, rf_reg_o}, {57'h0, ereg});
      chk("R9", rf_wdata_o & mask, edata);
    end
    for (int b = 0; b < 8; b++)
      if (ebe[b]) model[ereg][b*8 +: 8] = edata[b*8 +: 8];
    @(posedge clk_i);
    #1;
    chk("R7", rd_data_o, model[ereg]);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 128; r++) model[r] = '0;
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    // R10 reset state
    for (int r = 0; r < 128; r += 17) begin
      rd_addr_i = 7'(r); #1;
      chk("R10", rd_data_o, 64'h0);
    end
    // R1 full-width scalar-like write
    apply(1, 2'b00, 7'd3, 7'd10, 64'h0123_4567_89AB_CDEF, 1);
    // R3 fifth 16-bit element from r1 touches only low half of r2
    apply(1, 2'b00, 7'd0, 7'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    apply(1, 2'b10, 7'd4, 7'd1, 64'h0000_0000_0000_A5C3, 1);
    chk("R3", {56'h0, rf_be_o}, 64'h03);
    rd_addr_i = 7'd2; #1;
    chk("R3", rd_data_o, 64'hFFFF_FFFF_FFFF_A5C3);
    // R2 odd word
    apply(1, 2'b01, 7'd5, 7'd20, 64'hDEAD_BEEF_1234_5678, 1);
    // R4 single byte, last lane
    apply(1, 2'b11, 7'd15, 7'd30, 64'h77, 1);
    // R8 wrap
    apply(1, 2'b00, 7'd1, 7'd127, 64'h5555_AAAA_5555_AAAA, 1);
    apply(1, 2'b11, 7'd127, 7'd120, 64'h99, 1);
    // R5 / R6 no effect
    apply(1, 2'b00, 7'd0, 7'd10, 64'hFFFF_0000_FFFF_0000, 0);
    apply(0, 2'b00, 7'd0, 7'd10, 64'hFFFF_0000_FFFF_0000, 1);
    // R11 read of another register, same cycle as address change
    rd_addr_i = 7'd10; #1;
    chk("R11", rd_data_o, model[10]);
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      apply(rv[3:0] != 0, 2'($urandom), 7'($urandom), 7'($urandom),
            {$urandom, $urandom}, rv[7:4] > 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule